// File: doc/BRIEF.md
# One-Hot Fuse Blow and Readback Controller

This block holds a small bank of one-time-programmable fuse bits split into three registers: an 8-bit switch-point magnitude, a 1-bit field polarity and a 5-bit output/lock register. A key decoder upstream tells it which register was selected and whether the session is a permanent write (blow) session or a read session. Mid-level supply pulses then walk a one-hot address from bit 0 toward the register MSB.

In a blow session, a blow pulse sets exactly the addressed fuse. The controller then refuses further blows until the supply is cycled. In a read session, the readout pin reports the addressed fuse: low when blown, high when intact. Blown fuses accumulate by OR and are never cleared by a power cycle.

Bit 4 of the output/lock register is the lock fuse. Once it is blown, no register can be selected any more for blowing or reading. The asynchronous reset is a test-only clear: it empties every fuse and returns the controller to its idle state.

Top module: `otp_blow_ctrl`

## Requirements
- R1: A key event (`key_done_i` high for one cycle) that the controller accepts places the address on bit 0 (code 1). A blow pulse sent right after it sets bit 0 of the selected register. Register codes on `key_reg_i` are: 0 magnitude, 1 polarity, 2 output/lock, 3 no register (the key is rejected).
- R2: Each mid pulse moves the one-hot address one bit toward the MSB, so n mid pulses select code 2^n. A blow pulse sets only that one bit.
- R3: Blown fuses accumulate by OR and never clear. They persist across power-cycle events. For example, blowing bit 1 and later bit 0 gives code 3.
- R4: After a fuse is blown, every further blow pulse is ignored until a power-cycle event (`pwr_cycle_i`) re-arms the controller.
- R5: A mid pulse while the address is on the register MSB makes the address invalid. Further mid pulses keep it invalid, and a blow pulse at an invalid address changes no fuse.
- R6: In a read session (`key_read_i` = 1 at the key), `readout_o` is 0 when the addressed fuse is blown and 1 when it is intact. This holds after the key and after each mid pulse. Outside a read session, and at an invalid address, `readout_o` is 1.
- R7: A blow pulse during a read session changes no fuse.
- R8: `lock_o` equals the output/lock register bit 4, which is reached with four mid pulses. While it is set, key events are rejected: blow pulses change no fuse and `readout_o` stays 1.
- R9: The reset (`rst_n` low) clears all fuses and leaves the controller idle and armed, with `readout_o` = 1 and `lock_o` = 0.
- R10: A blow pulse affects only the register selected by the last accepted key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low test clear of fuses and state |
| key_done_i | input | 1 | One-cycle event: key decoder finished a selection |
| key_reg_i | input | 2 | Selected register code, valid with key_done_i |
| key_read_i | input | 1 | 1 = read session, 0 = blow session, valid with key_done_i |
| mid_pulse_i | input | 1 | One-cycle event: mid-level pulse, advances address |
| blow_pulse_i | input | 1 | One-cycle event: blow pulse |
| pwr_cycle_i | input | 1 | One-cycle event: supply cycled, ends session and re-arms |
| mag_fuse_o | output | MAG_W | Magnitude register fuse contents |
| pol_fuse_o | output | POL_W | Polarity register fuse contents |
| ol_fuse_o | output | OL_W | Output/lock register fuse contents |
| lock_o | output | 1 | Lock fuse state |
| readout_o | output | 1 | Read-session fuse readout |

## Verification
Every event is registered on the clock edge where it is seen high. Its result is due on the outputs right after that edge: fuse contents, the lock flag, and the readout, which decodes the registered address and fuses without further delay. The bench therefore raises each event at a falling edge and drops it at the next falling edge, and it samples the outputs at that same falling edge, exactly one cycle after the stimulus. Blocked-blow cases are checked at that same point and are checked again after a later power cycle, so that a delayed write would also be seen.

// File: rtl/otp_blow_pkg.sv
package otp_blow_pkg;
    typedef enum logic [1:0] {
        REG_MAG  = 2'd0,
        REG_POL  = 2'd1,
        REG_OUT  = 2'd2,
        REG_NONE = 2'd3
    } otp_reg_e;

    typedef struct packed {
        logic     active;
        logic     rd;
        otp_reg_e sel;
        logic     armed;
    } otp_ctl_t;
endpackage

// File: rtl/otp_onehot_addr.sv
module otp_onehot_addr #(
    parameter int AW = 8,
    localparam int IW = (AW > 1) ? $clog2(AW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic [IW-1:0] msb_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr_i) begin
            addr_d = '0;
        end else if (load_i) begin
            addr_d = AW'(1);
        end else if (shift_i) begin
            // leaving the top bit of the register empties the address
            addr_d = addr_q[msb_i] ? '0 : (addr_q << 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    p_addr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_q));
    p_load_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (addr_q == AW'(1)));
    p_past_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i && !clr_i && addr_q[msb_i]) |=> (addr_q == '0));
endmodule

// File: rtl/otp_fuse_reg.sv
module otp_fuse_reg #(
    parameter int AW = 8,
    parameter int W  = 8,
    localparam logic [AW-1:0] MASK = AW'((64'd1 << W) - 64'd1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blow_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] fuse_o
);
    logic [AW-1:0] fuse_d, fuse_q;

    always_comb begin
        fuse_d = fuse_q;
        if (blow_i) fuse_d = fuse_q | (addr_i & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fuse_q <= '0;
        else        fuse_q <= fuse_d;
    end

    assign fuse_o = fuse_q;

    p_fuse_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fuse_q) & ~fuse_q) == '0));
    p_one_bit_per_blow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fuse_q ^ $past(fuse_q)) <= 1));
    p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_q & ~MASK) == '0));
endmodule

// File: rtl/otp_blow_ctrl.sv
module otp_blow_ctrl
    import otp_blow_pkg::*;
#(
    parameter int MAG_W    = 8,
    parameter int POL_W    = 1,
    parameter int OL_W     = 5,
    parameter int LOCK_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_done_i,
    input  logic [1:0]       key_reg_i,
    input  logic             key_read_i,
    input  logic             mid_pulse_i,
    input  logic             blow_pulse_i,
    input  logic             pwr_cycle_i,
    output logic [MAG_W-1:0] mag_fuse_o,
    output logic [POL_W-1:0] pol_fuse_o,
    output logic [OL_W-1:0]  ol_fuse_o,
    output logic             lock_o,
    output logic             readout_o
);
    localparam int NREG   = 3;
    localparam int MX1    = (MAG_W > POL_W) ? MAG_W : POL_W;
    localparam int ADDR_W = (MX1 > OL_W) ? MX1 : OL_W;
    localparam int IW     = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
    localparam int REG_W [NREG] = '{MAG_W, POL_W, OL_W};

    otp_ctl_t st_d, st_q;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] fuse_all [NREG];
    logic [NREG-1:0]   blow_en;
    logic [ADDR_W-1:0] cur_fuse;
    logic [IW-1:0]     msb;
    logic              blow_ok, step_ok;

    assign lock_o = fuse_all[2][LOCK_BIT];

    // events are exclusive by priority: power cycle, key, blow/mid
    always_comb begin
        st_d    = st_q;
        blow_ok = st_q.active && !st_q.rd && st_q.armed && !lock_o
                  && blow_pulse_i && (|addr) && !pwr_cycle_i && !key_done_i;
        step_ok = st_q.active && mid_pulse_i && !pwr_cycle_i && !key_done_i;
        if (pwr_cycle_i) begin
            st_d.active = 1'b0;
            st_d.armed  = 1'b1;
        end else if (key_done_i) begin
            st_d.active = !lock_o && (otp_reg_e'(key_reg_i) != REG_NONE);
            st_d.rd     = key_read_i;
            st_d.sel    = otp_reg_e'(key_reg_i);
        end else if (blow_ok) begin
            st_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, rd: 1'b0, sel: REG_NONE, armed: 1'b1};
        else        st_q <= st_d;
    end

    always_comb begin
        msb      = '0;
        cur_fuse = '0;
        for (int r = 0; r < NREG; r++) begin
            if (st_q.sel == otp_reg_e'(r)) begin
                msb      = IW'(REG_W[r] - 1);
                cur_fuse = fuse_all[r];
            end
        end
    end

    otp_onehot_addr #(.AW(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pwr_cycle_i),
        .load_i  (key_done_i),
        .shift_i (step_ok),
        .msb_i   (msb),
        .addr_o  (addr)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign blow_en[g] = blow_ok && (st_q.sel == otp_reg_e'(g));
        otp_fuse_reg #(.AW(ADDR_W), .W(REG_W[g])) u_fuse (
            .clk    (clk),
            .rst_n  (rst_n),
            .blow_i (blow_en[g]),
            .addr_i (addr),
            .fuse_o (fuse_all[g])
        );
    end

    assign readout_o  = !(st_q.active && st_q.rd && (|(addr & cur_fuse)));
    assign mag_fuse_o = fuse_all[0][MAG_W-1:0];
    assign pol_fuse_o = fuse_all[1][POL_W-1:0];
    assign ol_fuse_o  = fuse_all[2][OL_W-1:0];

    p_disarmed_no_blow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> ($stable(fuse_all[0]) && $stable(fuse_all[1]) && $stable(fuse_all[2])));
    p_read_no_blow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.rd) |=> ($stable(fuse_all[0]) && $stable(fuse_all[1]) && $stable(fuse_all[2])));
    p_locked_readout_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> readout_o);
    p_blow_one_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blow_en));
endmodule

// File: tb/otp_blow_ctrl_tb.sv
module otp_blow_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_done_i = 1'b0, key_read_i = 1'b0;
    logic [1:0] key_reg_i = 2'd0;
    logic       mid_pulse_i = 1'b0, blow_pulse_i = 1'b0, pwr_cycle_i = 1'b0;
    logic [7:0] mag_fuse_o;
    logic [0:0] pol_fuse_o;
    logic [4:0] ol_fuse_o;
    logic       lock_o, readout_o;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    otp_blow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .key_done_i(key_done_i), .key_reg_i(key_reg_i),
        .key_read_i(key_read_i), .mid_pulse_i(mid_pulse_i), .blow_pulse_i(blow_pulse_i),
        .pwr_cycle_i(pwr_cycle_i), .mag_fuse_o(mag_fuse_o), .pol_fuse_o(pol_fuse_o),
        .ol_fuse_o(ol_fuse_o), .lock_o(lock_o), .readout_o(readout_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic key(input int r, input bit rd);
        @(negedge clk);
        key_done_i = 1'b1; key_reg_i = 2'(r); key_read_i = rd;
        @(negedge clk);
        key_done_i = 1'b0;
    endtask

    task automatic mids(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mid_pulse_i = 1'b1;
            @(negedge clk); mid_pulse_i = 1'b0;
        end
    endtask

    task automatic blow();
        @(negedge clk); blow_pulse_i = 1'b1;
        @(negedge clk); blow_pulse_i = 1'b0;
    endtask

    task automatic pwr();
        @(negedge clk); pwr_cycle_i = 1'b1;
        @(negedge clk); pwr_cycle_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9", "mag after reset", mag_fuse_o, 0);
        chk("R9", "pol after reset", pol_fuse_o, 0);
        chk("R9", "out/lock after reset", ol_fuse_o, 0);
        chk("R9", "lock after reset", lock_o, 0);
        chk("R9", "readout idle", readout_o, 1);
    endtask

    task automatic t_shift_blow();
        key(0, 0); mids(3); blow();
        chk("R2", "three mids then blow", mag_fuse_o, 8'h08);
        chk("R10", "pol untouched", pol_fuse_o, 0);
        chk("R10", "out/lock untouched", ol_fuse_o, 0);
        pwr(); key(0, 0); blow();
        chk("R1", "blow right after key", mag_fuse_o, 8'h09);
        chk("R6", "readout high in blow session", readout_o, 1);
        pwr();
    endtask

    task automatic t_single_blow();
        key(0, 0); mids(1); blow();
        chk("R2", "bit1 blown", mag_fuse_o, 8'h0B);
        mids(1); blow();
        chk("R4", "second blow ignored", mag_fuse_o, 8'h0B);
        pwr();
        chk("R4", "still ignored after power cycle", mag_fuse_o, 8'h0B);
        key(0, 0); mids(2); blow();
        chk("R4", "re-armed after power cycle", mag_fuse_o, 8'h0F);
        pwr();
    endtask

    task automatic t_accumulate();
        key(2, 0); mids(1); blow();
        chk("R3", "out/lock bit1", ol_fuse_o, 5'h02);
        pwr(); key(2, 0); blow();
        chk("R3", "bit1 then bit0 gives 3", ol_fuse_o, 5'h03);
        chk("R10", "mag kept", mag_fuse_o, 8'h0F);
        pwr();
    endtask

    task automatic t_overflow();
        key(1, 0); mids(1); blow();
        chk("R5", "pol blow past msb", pol_fuse_o, 0);
        mids(2); blow();
        chk("R5", "pol still invalid", pol_fuse_o, 0);
        pwr(); key(0, 0); mids(8); blow();
        chk("R5", "mag blow past msb", mag_fuse_o, 8'h0F);
        pwr(); key(3, 0); blow();
        chk("R1", "rejected key, no blow", {mag_fuse_o, pol_fuse_o, ol_fuse_o}, {8'h0F, 1'b0, 5'h03});
        pwr(); key(1, 0); blow();
        chk("R3", "pol blown", pol_fuse_o, 1);
        pwr();
    endtask

    task automatic t_read();
        key(0, 1);
        for (int i = 0; i < 8; i++) begin
            if (i > 0) mids(1);
            chk("R6", $sformatf("readout bit %0d", i), readout_o, (i < 4) ? 0 : 1);
        end
        mids(1);
        chk("R6", "readout invalid addr", readout_o, 1);
        pwr(); key(0, 1); blow();
        chk("R7", "blow in read session", mag_fuse_o, 8'h0F);
        chk("R7", "readout still bit0 blown", readout_o, 0);
        pwr();
    endtask

    task automatic t_lock();
        key(2, 0); mids(4); blow();
        chk("R8", "lock fuse set", lock_o, 1);
        chk("R8", "out/lock code", ol_fuse_o, 5'h13);
        pwr(); key(0, 0); mids(5); blow();
        chk("R8", "locked blow ignored", mag_fuse_o, 8'h0F);
        pwr(); key(2, 1);
        chk("R8", "locked read high", readout_o, 1);
        pwr();
        chk("R3", "fuses persist", {mag_fuse_o, pol_fuse_o, ol_fuse_o}, {8'h0F, 1'b1, 5'h13});
    endtask

    task automatic t_clear();
        do_reset();
        chk("R9", "clear empties fuses", {mag_fuse_o, pol_fuse_o, ol_fuse_o}, 0);
        chk("R9", "clear drops lock", lock_o, 0);
        key(1, 0); blow();
        chk("R9", "armed after clear", pol_fuse_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shift_blow();
        t_single_blow();
        t_accumulate();
        t_overflow();
        t_read();
        t_lock();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule